// File: doc/BRIEF.md
# Vectored Trap Return Target Resolver

This block works out where the program counter goes when a trap-return instruction retires. For an ordinary return the new PC is the saved exception PC, with the low bits cleared to instruction alignment. Bit 0 is cleared when compressed instructions are supported, and bits 1:0 when they are not.

When the saved cause marks the trap as a hardware-vectored interrupt, the saved exception PC is not the resume address. It names an entry in the trap vector table, and that entry holds a function pointer.

- The block clears the entry address down to table-entry alignment (XLEN/8 bytes). It never raises a misalignment trap for this address.
- It fetches the pointer through a single-beat read port with a request/grant handshake.
- It redirects to the loaded pointer, aligned by the normal instruction rule.
- If the read comes back with an error, it reports an instruction access fault carrying the table address instead of redirecting.

The controller has four states:

- `IDLE` waits for a return request. It goes to `REDIRECT` on a plain return and to `TABLE_READ` on a vectored one.
- `TABLE_READ` holds the read request until it is granted, then goes to `WAIT_DATA`.
- `WAIT_DATA` waits for the response, then goes to `REDIRECT`.
- `REDIRECT` pulses either the redirect or the fault output for one cycle, then goes back to `IDLE`.

Top module: `vtr_resolver`

## Requirements
- R1: After reset, and while no request has been taken, `redir_valid_o`, `fault_valid_o` and `mem_req_o` are all 0.
- R2: When `ret_req_i` is high in `IDLE` with `vec_mode_i` low, `redir_valid_o` is high in the next cycle. `redir_pc_o` is then `epc_i` with bit 0 cleared if `HAS_COMPRESSED` is 1, or with bits 1:0 cleared if it is 0.
- R3: When `ret_req_i` is high in `IDLE` with `vec_mode_i` high, `mem_req_o` is high from the next cycle. `mem_addr_o` is `epc_i` with its low log2(XLEN/8) bits cleared, whatever the value of `HAS_COMPRESSED`. No fault is raised for a misaligned `epc_i`.
- R4: While `mem_req_o` is high and `mem_gnt_i` is low, `mem_req_o` stays high and `mem_addr_o` stays unchanged. `mem_req_o` drops in the cycle after the grant.
- R5: When `mem_rvalid_i` is high in `WAIT_DATA` with `mem_err_i` low, `redir_valid_o` is high in the next cycle. `redir_pc_o` is then `mem_rdata_i` aligned by the rule of R2.
- R6: When `mem_rvalid_i` is high in `WAIT_DATA` with `mem_err_i` high, `fault_valid_o` is high in the next cycle and `fault_addr_o` equals the table address. `redir_valid_o` stays low.
- R7: `redir_valid_o` and `fault_valid_o` each last exactly one cycle, and they are never high together.
- R8: A `ret_req_i` that arrives in any state other than `IDLE` has no effect. This includes the cycle in which the redirect or the fault is shown. A `mem_rvalid_i` that arrives outside `WAIT_DATA` also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_req_i | input | 1 | Trap return retires this cycle |
| epc_i | input | XLEN | Saved exception PC |
| vec_mode_i | input | 1 | Saved cause marks a hardware-vectored interrupt |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | XLEN | Table entry address |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | XLEN | Loaded pointer |
| mem_err_i | input | 1 | Read response carries an error |
| redir_valid_o | output | 1 | Redirect pulse |
| redir_pc_o | output | XLEN | Redirect target |
| fault_valid_o | output | 1 | Instruction access fault pulse |
| fault_addr_o | output | XLEN | Faulting table address |

## Verification
A wrong state in the controller shows at the ports within one cycle:

- a read request that is missing or extra,
- a redirect pulse that comes early, twice, or not at all,
- a fault pulse where a redirect was due.

A wrong value in the datapath shows on `mem_addr_o` as soon as the request rises, or on the redirect or fault outputs in their single valid cycle. The reference model is therefore compared with both a compressed-capable and a word-only instance on every cycle. Ignored requests and stray responses are placed in every busy state, so that a leaked transition shows up as an extra pulse or a wrong target.

// File: rtl/vtr_pkg.sv
package vtr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_TABLE_READ = 2'd1,
        ST_WAIT_DATA  = 2'd2,
        ST_REDIRECT   = 2'd3
    } vtr_state_e;

    // Number of low address bits cleared for an instruction fetch target
    function automatic int ins_lsb(input bit has_c);
        return has_c ? 1 : 2;
    endfunction

endpackage

// File: rtl/vtr_align_mask.sv
module vtr_align_mask #(
    parameter int W   = 32,
    parameter int CLR = 1
) (
    input  logic [W-1:0] addr_i,
    output logic [W-1:0] addr_o
);

    generate
        if (CLR == 0) begin : g_pass
            assign addr_o = addr_i;
        end else begin : g_clear
            assign addr_o = {addr_i[W-1:CLR], {CLR{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/vtr_ctrl.sv
module vtr_ctrl
    import vtr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ret_req_i,
    input  logic vec_mode_i,
    input  logic mem_gnt_i,
    input  logic mem_rvalid_i,
    output logic take_direct_o,
    output logic take_vector_o,
    output logic take_rsp_o,
    output logic mem_req_o,
    output logic report_o
);

    vtr_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ret_req_i) state_d = vec_mode_i ? ST_TABLE_READ : ST_REDIRECT;
            end
            ST_TABLE_READ: begin
                if (mem_gnt_i) state_d = ST_WAIT_DATA;
            end
            ST_WAIT_DATA: begin
                if (mem_rvalid_i) state_d = ST_REDIRECT;
            end
            ST_REDIRECT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        take_direct_o = 1'b0;
        take_vector_o = 1'b0;
        take_rsp_o    = 1'b0;
        mem_req_o     = 1'b0;
        report_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                take_direct_o = ret_req_i && !vec_mode_i;
                take_vector_o = ret_req_i &&  vec_mode_i;
            end
            ST_TABLE_READ: mem_req_o  = 1'b1;
            ST_WAIT_DATA:  take_rsp_o = mem_rvalid_i;
            ST_REDIRECT:   report_o   = 1'b1;
            default: ;
        endcase
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_gnt_i |=> mem_req_o) else $error("request dropped"); // R4

    AST_REQ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_gnt_i |=> !mem_req_o) else $error("request after grant"); // R4

    AST_REPORT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        report_o |=> !report_o) else $error("report longer than one cycle"); // R7

endmodule

// File: rtl/vtr_datapath.sv
module vtr_datapath #(
    parameter int XLEN           = 32,
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] epc_i,
    input  logic [XLEN-1:0] rdata_i,
    input  logic            err_i,
    input  logic            take_direct_i,
    input  logic            take_vector_i,
    input  logic            take_rsp_i,
    input  logic            mem_req_i,
    input  logic            mem_gnt_i,
    output logic [XLEN-1:0] tbl_addr_o,
    output logic [XLEN-1:0] target_o,
    output logic            fault_o
);

    localparam int TBL_LSB = $clog2(XLEN / 8);
    localparam int INS_LSB = vtr_pkg::ins_lsb(HAS_COMPRESSED);

    logic [XLEN-1:0] tbl_addr_q, target_q;
    logic            fault_q;
    logic [XLEN-1:0] tbl_masked, tgt_src, tgt_masked;

    vtr_align_mask #(.W(XLEN), .CLR(TBL_LSB)) i_tbl_mask (
        .addr_i (epc_i),
        .addr_o (tbl_masked)
    );

    assign tgt_src = take_direct_i ? epc_i : rdata_i;

    vtr_align_mask #(.W(XLEN), .CLR(INS_LSB)) i_ins_mask (
        .addr_i (tgt_src),
        .addr_o (tgt_masked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_addr_q <= '0;
            target_q   <= '0;
            fault_q    <= 1'b0;
        end else begin
            if (take_vector_i) begin
                tbl_addr_q <= tbl_masked;
                fault_q    <= 1'b0;
            end
            if (take_direct_i) begin
                target_q <= tgt_masked;
                fault_q  <= 1'b0;
            end
            if (take_rsp_i) begin
                fault_q <= err_i;
                if (!err_i) target_q <= tgt_masked;
            end
        end
    end

    assign tbl_addr_o = tbl_addr_q;
    assign target_o   = target_q;
    assign fault_o    = fault_q;

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_i && !mem_gnt_i |=> $stable(tbl_addr_q)) else $error("table address moved"); // R4

    AST_TBL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_i |-> tbl_addr_q[TBL_LSB-1:0] == '0) else $error("table address misaligned"); // R3

endmodule

// File: rtl/vtr_resolver.sv
module vtr_resolver #(
    parameter int XLEN           = 32,
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ret_req_i,
    input  logic [XLEN-1:0] epc_i,
    input  logic            vec_mode_i,
    output logic            mem_req_o,
    output logic [XLEN-1:0] mem_addr_o,
    input  logic            mem_gnt_i,
    input  logic            mem_rvalid_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    input  logic            mem_err_i,
    output logic            redir_valid_o,
    output logic [XLEN-1:0] redir_pc_o,
    output logic            fault_valid_o,
    output logic [XLEN-1:0] fault_addr_o
);

    localparam int INS_LSB = vtr_pkg::ins_lsb(HAS_COMPRESSED);

    logic take_direct, take_vector, take_rsp, report, fault;
    logic [XLEN-1:0] tbl_addr, target;

    vtr_ctrl i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ret_req_i     (ret_req_i),
        .vec_mode_i    (vec_mode_i),
        .mem_gnt_i     (mem_gnt_i),
        .mem_rvalid_i  (mem_rvalid_i),
        .take_direct_o (take_direct),
        .take_vector_o (take_vector),
        .take_rsp_o    (take_rsp),
        .mem_req_o     (mem_req_o),
        .report_o      (report)
    );

    vtr_datapath #(.XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED)) i_datapath (
        .clk           (clk),
        .rst_n         (rst_n),
        .epc_i         (epc_i),
        .rdata_i       (mem_rdata_i),
        .err_i         (mem_err_i),
        .take_direct_i (take_direct),
        .take_vector_i (take_vector),
        .take_rsp_i    (take_rsp),
        .mem_req_i     (mem_req_o),
        .mem_gnt_i     (mem_gnt_i),
        .tbl_addr_o    (tbl_addr),
        .target_o      (target),
        .fault_o       (fault)
    );

    assign mem_addr_o    = tbl_addr;
    assign redir_pc_o    = target;
    assign fault_addr_o  = tbl_addr;
    assign redir_valid_o = report && !fault;
    assign fault_valid_o = report &&  fault;

    AST_TGT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |-> redir_pc_o[INS_LSB-1:0] == '0) else $error("target misaligned"); // R2

    AST_NO_REQ_AT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid_o || fault_valid_o) |-> !mem_req_o) else $error("request while reporting"); // R8

    AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |=> !fault_valid_o) else $error("fault right after redirect"); // R7

endmodule

// File: tb/test_vtr_resolver.sv
module test_vtr_resolver;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ret_req = 1'b0;
    logic [XLEN-1:0] epc = '0;
    logic            vec = 1'b0;
    logic            gnt = 1'b0;
    logic            rvalid = 1'b0;
    logic [XLEN-1:0] rdata = '0;
    logic            err = 1'b0;

    logic            req_c, req_w, rv_c, rv_w, fv_c, fv_w;
    logic [XLEN-1:0] addr_c, addr_w, pc_c, pc_w, fa_c, fa_w;

    int errs = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    vtr_resolver #(.XLEN(XLEN), .HAS_COMPRESSED(1'b1)) i_vtr_resolver (
        .clk (clk), .rst_n (rst_n), .ret_req_i (ret_req), .epc_i (epc), .vec_mode_i (vec),
        .mem_req_o (req_c), .mem_addr_o (addr_c), .mem_gnt_i (gnt), .mem_rvalid_i (rvalid),
        .mem_rdata_i (rdata), .mem_err_i (err), .redir_valid_o (rv_c), .redir_pc_o (pc_c),
        .fault_valid_o (fv_c), .fault_addr_o (fa_c)
    );

    // Same stimulus, no compressed support
    vtr_resolver #(.XLEN(XLEN), .HAS_COMPRESSED(1'b0)) i_vtr_resolver_nc (
        .clk (clk), .rst_n (rst_n), .ret_req_i (ret_req), .epc_i (epc), .vec_mode_i (vec),
        .mem_req_o (req_w), .mem_addr_o (addr_w), .mem_gnt_i (gnt), .mem_rvalid_i (rvalid),
        .mem_rdata_i (rdata), .mem_err_i (err), .redir_valid_o (rv_w), .redir_pc_o (pc_w),
        .fault_valid_o (fv_w), .fault_addr_o (fa_w)
    );

    // Behavioural reference: what the ports should show in the coming cycle
    bit              m_busy_req;    // waiting for grant
    bit              m_busy_rsp;    // waiting for response
    bit              m_show;        // one-cycle report pending
    bit              m_flt;
    logic [XLEN-1:0] m_tab, m_pc_c, m_pc_w;

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        chk("R3 mem_req (c)", {31'd0, req_c}, {31'd0, m_busy_req});
        chk("R3 mem_req (w)", {31'd0, req_w}, {31'd0, m_busy_req});
        if (m_busy_req) begin
            chk("R4 mem_addr (c)", addr_c, m_tab);
            chk("R4 mem_addr (w)", addr_w, m_tab);
        end
        chk("R5 redir_valid (c)", {31'd0, rv_c}, {31'd0, m_show && !m_flt});
        chk("R5 redir_valid (w)", {31'd0, rv_w}, {31'd0, m_show && !m_flt});
        if (m_show && !m_flt) begin
            chk("R2 redir_pc (c)", pc_c, m_pc_c);
            chk("R2 redir_pc (w)", pc_w, m_pc_w);
        end
        chk("R6 fault_valid (c)", {31'd0, fv_c}, {31'd0, m_show && m_flt});
        chk("R6 fault_valid (w)", {31'd0, fv_w}, {31'd0, m_show && m_flt});
        if (m_show && m_flt) begin
            chk("R6 fault_addr (c)", fa_c, m_tab);
            chk("R6 fault_addr (w)", fa_w, m_tab);
        end
        chk("R7 exclusive (c)", {31'd0, rv_c && fv_c}, '0);
    endtask

    // One cycle: compare at negedge, drive, then advance the model at posedge
    task automatic cyc(input bit r, input logic [XLEN-1:0] e, input bit v,
                       input bit g, input bit rv, input logic [XLEN-1:0] d, input bit er);
        @(negedge clk);
        compare_all();
        ret_req = r; epc = e; vec = v; gnt = g; rvalid = rv; rdata = d; err = er;
        @(posedge clk);
        cycles++;
        if (m_show) begin
            m_show = 0;                         // R8: request here ignored
        end else if (m_busy_rsp) begin
            if (rv) begin
                m_busy_rsp = 0; m_show = 1; m_flt = er;
                if (!er) begin
                    m_pc_c = d & ~32'h1;
                    m_pc_w = d & ~32'h3;
                end
            end
        end else if (m_busy_req) begin
            if (g) begin m_busy_req = 0; m_busy_rsp = 1; end
        end else if (r) begin
            if (v) begin
                m_tab = e & ~32'h3; m_busy_req = 1;
            end else begin
                m_show = 1; m_flt = 0;
                m_pc_c = e & ~32'h1;
                m_pc_w = e & ~32'h3;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0, '0, 0);
    endtask

    initial begin
        m_busy_req = 0; m_busy_rsp = 0; m_show = 0; m_flt = 0;
        m_tab = '0; m_pc_c = '0; m_pc_w = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset redir", {31'd0, rv_c || rv_w}, '0);
        chk("R1 reset fault", {31'd0, fv_c || fv_w}, '0);
        chk("R1 reset req",   {31'd0, req_c || req_w}, '0);
        rst_n = 1'b1;
        idle(2);

        // R2: plain return, odd address
        cyc(1, 32'h1000_0003, 0, 0, 0, '0, 0);
        idle(2);
        // R2 back to back; second request lands on the report cycle (R8)
        cyc(1, 32'h0000_4006, 0, 0, 0, '0, 0);
        cyc(1, 32'hDEAD_BEEF, 0, 0, 0, '0, 0);
        cyc(1, 32'h0000_8005, 0, 0, 0, '0, 0);
        idle(2);

        // R3/R4/R5: vectored, misaligned epc, grant after wait, stray rvalid in TABLE_READ
        cyc(1, 32'h2000_0106, 1, 0, 0, '0, 0);
        cyc(0, '0, 0, 0, 1, 32'hFFFF_FFFF, 0);  // R8 stray response ignored
        cyc(1, 32'h3333_3333, 0, 0, 0, '0, 0);  // R8 request while requesting
        cyc(0, '0, 0, 1, 0, '0, 0);
        cyc(1, 32'h4444_4444, 1, 0, 0, '0, 0);  // R8 request while waiting
        cyc(0, '0, 0, 0, 1, 32'h8000_0043, 0);
        cyc(1, 32'h5555_5555, 0, 0, 0, '0, 0);  // R8 request in report cycle
        idle(2);

        // R3: epc with both low bits set, immediate grant
        cyc(1, 32'h0000_0FFF, 1, 1, 0, '0, 0);
        cyc(0, '0, 0, 1, 0, '0, 0);
        cyc(0, '0, 0, 0, 1, 32'h1234_5676, 0);
        idle(2);

        // R6: error response gives fault with table address
        cyc(1, 32'h0000_0202, 1, 0, 0, '0, 0);
        cyc(0, '0, 0, 1, 0, '0, 0);
        cyc(0, '0, 0, 0, 0, '0, 0);
        cyc(0, '0, 0, 0, 1, 32'hAAAA_AAAA, 1);
        idle(2);

        // Plain return right after a fault: target must not be stale
        cyc(1, 32'h0000_0010, 0, 0, 0, '0, 0);
        idle(3);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule